// File: doc/BRIEF.md
# Stereo Audio Sample Input Formatter

This block is the host-facing front end of a stereo audio bitstream converter. Software, or a transfer engine, writes audio words into two sample registers. The block unpacks each word according to a selectable word format and holds one complete stereo frame in a buffer. When the downstream modulator pulses its sample request, the buffered frame moves into two output holding registers. Each holding register carries a 16-bit two's-complement sample for one channel.

Two status flags pace the writer. A ready flag shows that the block is enabled and has room for a new frame. A sticky underrun flag records that the modulator asked for a sample before a frame was complete. On an underrun, the previous frame is repeated. A mono control and a channel-swap control change how register writes land in the two channels. Two compact formats pack both channels into one register word, so only one write is needed per frame.

Top module: `audio_sample_formatter`

## Requirements
- R1: While reset is applied and on the first cycle after it, tx_ready_o and tx_underrun_o are 0 and both channel outputs are 0.
- R2: tx_ready_o is 1 when the block is enabled and holds no complete frame. It falls on the clock edge of the write that completes a frame. It rises again on the edge of a sample request that consumes the frame.
- R3: In stereo (non-mono, non-compact) formats, a frame is complete only after both sample register A (address 0) and sample register B (address 1) have been written. Writing A alone leaves tx_ready_o at 1.
- R4: A sample request while a frame is complete loads both channel outputs on that clock edge. A request while no frame is complete sets tx_underrun_o on that edge and leaves the outputs unchanged. tx_underrun_o then stays set.
- R5: tx_underrun_o is cleared by a write to address 2, and it is cleared by disabling the block.
- R6: fmt_i codes 0, 1, 2 and 3 select word widths of 32, 24, 20 and 18 bits, and the output is data[W-1:W-16]. Code 4 selects a 16-bit word, and the output is data[15:0]. Bits above the word width are ignored.
- R7: Code 6 selects an 8-bit word. The output is {data[7:0], 8'h00}.
- R8: Code 5 selects compact 16-bit. Channel 0 comes from data[15:0] and channel 1 comes from data[31:16] of one register A write, and that single write completes the frame.
- R9: Code 7 selects compact 8-bit. Channel 0 comes from {data[7:0],8'h00} and channel 1 comes from {data[15:8],8'h00} of one register A write, and that single write completes the frame.
- R10: With swap_i set in a non-compact, non-mono format, a write to register A feeds channel 1 and a write to register B feeds channel 0.
- R11: With swap_i set in a compact format, the two halves of the register A word are exchanged before they reach the channels.
- R12: In mono mode (mono_i set, non-compact format), one register A write completes the frame and its sample drives both channels. In mono and in compact formats, writes to register B are ignored and do not complete a frame.
- R13: While en_i is 0, tx_ready_o is 0 and register writes and sample requests have no effect on the buffered frame or on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Block enable |
| fmt_i | input | 3 | Word format code (see R6 to R9) |
| mono_i | input | 1 | Mono mode |
| swap_i | input | 1 | Channel swap |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 = sample A, 1 = sample B, 2 = clear underrun |
| wr_data_i | input | 32 | Write data |
| samp_req_i | input | 1 | Sample request strobe from the modulator |
| tx_ready_o | output | 1 | Ready for a new frame |
| tx_underrun_o | output | 1 | Sticky underrun flag |
| ch0_o | output | 16 | Channel 0 sample |
| ch1_o | output | 16 | Channel 1 sample |

## Verification
Every result of this block appears on the clock edge that captures its cause. The ready flag changes on the edge of the completing write or the consuming request. The channel outputs and the underrun flag change on the edge of the request. The bench drives each strobe for one cycle starting at a falling edge. It reads the status flags at the next falling edge after that strobe. A monitor pops the expected channel values and underrun state from a queue at the falling edge that follows each request edge.

// File: rtl/asf_pkg.sv
package asf_pkg;
  typedef enum logic [2:0] {
    FMT_W32 = 3'd0,
    FMT_W24 = 3'd1,
    FMT_W20 = 3'd2,
    FMT_W18 = 3'd3,
    FMT_W16 = 3'd4,
    FMT_C16 = 3'd5,
    FMT_W8  = 3'd6,
    FMT_C8  = 3'd7
  } fmt_e;

  localparam int unsigned ADDR_SAMP_A = 0;
  localparam int unsigned ADDR_SAMP_B = 1;
  localparam int unsigned ADDR_CLEAR  = 2;

  function automatic logic fmt_is_compact(fmt_e f);
    return (f == FMT_C16) || (f == FMT_C8);
  endfunction
endpackage

// File: rtl/asf_unpack.sv
module asf_unpack
  import asf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SAMP_W = 16
) (
  input  fmt_e              fmt,
  input  logic [DATA_W-1:0] data,
  output logic [SAMP_W-1:0] lo,
  output logic [SAMP_W-1:0] hi
);
  localparam int PAD_W = SAMP_W - 8;
  localparam logic [PAD_W-1:0] PAD = '0;

  always_comb begin
    lo = '0;
    hi = '0;
    case (fmt)
      FMT_W32: lo = data[31 -: SAMP_W];
      FMT_W24: lo = data[23 -: SAMP_W];
      FMT_W20: lo = data[19 -: SAMP_W];
      FMT_W18: lo = data[17 -: SAMP_W];
      FMT_W16: lo = data[SAMP_W-1:0];
      FMT_C16: begin
        lo = data[SAMP_W-1:0];
        hi = data[2*SAMP_W-1:SAMP_W];
      end
      FMT_W8:  lo = {data[7:0], PAD};
      FMT_C8: begin
        lo = {data[7:0], PAD};
        hi = {data[15:8], PAD};
      end
      default: lo = '0;
    endcase
  end
endmodule

// File: rtl/asf_frame_buf.sv
module asf_frame_buf #(
  parameter int SAMP_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              take,
  input  logic              wr_a,
  input  logic              wr_b,
  input  logic              compact,
  input  logic              mono,
  input  logic              swap,
  input  logic [SAMP_W-1:0] lo,
  input  logic [SAMP_W-1:0] hi,
  output logic [SAMP_W-1:0] slot0,
  output logic [SAMP_W-1:0] slot1,
  output logic              full,
  output logic              full_next
);
  localparam int NCH = 2;

  logic [NCH-1:0]    got_q, got_n, we;
  logic [SAMP_W-1:0] d_w   [NCH];
  logic [SAMP_W-1:0] slot_q[NCH];

  always_comb begin
    we     = '0;
    d_w[0] = lo;
    d_w[1] = lo;
    if (wr_a) begin
      if (compact) begin
        we     = '1;
        d_w[0] = swap ? hi : lo;
        d_w[1] = swap ? lo : hi;
      end else if (mono) begin
        we = '1;
      end else begin
        we[swap] = 1'b1;
      end
    end
    if (wr_b && !compact && !mono) we[~swap] = 1'b1;
  end

  assign got_n     = en ? ((take ? '0 : got_q) | we) : '0;
  assign full_next = &got_n;
  assign full      = &got_q;

  always_ff @(posedge clk) begin
    if (rst) got_q <= '0;
    else     got_q <= got_n;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)             slot_q[i] <= '0;
      else if (en && we[i]) slot_q[i] <= d_w[i];
    end
  end

  assign slot0 = slot_q[0];
  assign slot1 = slot_q[1];
endmodule

// File: rtl/asf_out_stage.sv
module asf_out_stage #(
  parameter int SAMP_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              req,
  input  logic              full,
  input  logic              clr,
  input  logic [SAMP_W-1:0] slot0,
  input  logic [SAMP_W-1:0] slot1,
  output logic              take,
  output logic              underrun,
  output logic [SAMP_W-1:0] ch0,
  output logic [SAMP_W-1:0] ch1
);
  localparam int NCH = 2;

  logic [SAMP_W-1:0] src  [NCH];
  logic [SAMP_W-1:0] hold [NCH];

  assign take   = en && req && full;
  assign src[0] = slot0;
  assign src[1] = slot1;

  for (genvar i = 0; i < NCH; i++) begin : g_hold
    always_ff @(posedge clk) begin
      if (rst)       hold[i] <= '0;
      else if (take) hold[i] <= src[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en)         underrun <= 1'b0;
    else if (req && !full)  underrun <= 1'b1;
    else if (clr)           underrun <= 1'b0;
  end

  assign ch0 = hold[0];
  assign ch1 = hold[1];
endmodule

// File: rtl/audio_sample_formatter.sv
module audio_sample_formatter
  import asf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SAMP_W = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic [2:0]        fmt_i,
  input  logic              mono_i,
  input  logic              swap_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              samp_req_i,
  output logic              tx_ready_o,
  output logic              tx_underrun_o,
  output logic [SAMP_W-1:0] ch0_o,
  output logic [SAMP_W-1:0] ch1_o
);
  localparam logic [ADDR_W-1:0] A_ADDR = ADDR_W'(ADDR_SAMP_A);
  localparam logic [ADDR_W-1:0] B_ADDR = ADDR_W'(ADDR_SAMP_B);
  localparam logic [ADDR_W-1:0] C_ADDR = ADDR_W'(ADDR_CLEAR);

  fmt_e              fmt;
  logic              wr_a, wr_b, wr_clr, compact;
  logic [SAMP_W-1:0] lo, hi, slot0, slot1;
  logic              full, full_next, take, ready_q;

  assign fmt     = fmt_e'(fmt_i);
  assign compact = fmt_is_compact(fmt);
  assign wr_a    = en_i && wr_en_i && (wr_addr_i == A_ADDR);
  assign wr_b    = en_i && wr_en_i && (wr_addr_i == B_ADDR);
  assign wr_clr  = wr_en_i && (wr_addr_i == C_ADDR);

  asf_unpack #(.DATA_W(DATA_W), .SAMP_W(SAMP_W)) u_unpack (
    .fmt  (fmt),
    .data (wr_data_i),
    .lo   (lo),
    .hi   (hi)
  );

  asf_frame_buf #(.SAMP_W(SAMP_W)) u_buf (
    .clk       (clk),
    .rst       (rst),
    .en        (en_i),
    .take      (take),
    .wr_a      (wr_a),
    .wr_b      (wr_b),
    .compact   (compact),
    .mono      (mono_i),
    .swap      (swap_i),
    .lo        (lo),
    .hi        (hi),
    .slot0     (slot0),
    .slot1     (slot1),
    .full      (full),
    .full_next (full_next)
  );

  asf_out_stage #(.SAMP_W(SAMP_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .en       (en_i),
    .req      (samp_req_i),
    .full     (full),
    .clr      (wr_clr),
    .slot0    (slot0),
    .slot1    (slot1),
    .take     (take),
    .underrun (tx_underrun_o),
    .ch0      (ch0_o),
    .ch1      (ch1_o)
  );

  always_ff @(posedge clk) begin
    if (rst) ready_q <= 1'b0;
    else     ready_q <= en_i && !full_next;
  end

  assign tx_ready_o = ready_q;
endmodule

// File: rtl/asf_checker.sv
module asf_checker #(
  parameter int SAMP_W = 16,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              en_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic              samp_req_i,
  input logic              tx_ready_o,
  input logic              tx_underrun_o,
  input logic [SAMP_W-1:0] ch0_o,
  input logic [SAMP_W-1:0] ch1_o
);
  logic clr_wr;
  assign clr_wr = wr_en_i && (wr_addr_i == ADDR_W'(2));

  AST_READY_OFF_DISABLED: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !tx_ready_o); // R13
  AST_READY_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    en_i && samp_req_i && !wr_en_i |=> tx_ready_o); // R2
  AST_UNDERRUN_SET: assert property (@(posedge clk) disable iff (rst)
    en_i && samp_req_i && tx_ready_o |=> tx_underrun_o); // R4
  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
    tx_underrun_o && en_i && !clr_wr |=> tx_underrun_o); // R4
  AST_UNDERRUN_CLR_DISABLE: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !tx_underrun_o); // R5
  AST_REPEAT_ON_UNDERRUN: assert property (@(posedge clk) disable iff (rst)
    samp_req_i && tx_ready_o |=> $stable(ch0_o) && $stable(ch1_o)); // R4
  AST_HOLD_WITHOUT_REQ: assert property (@(posedge clk) disable iff (rst)
    !samp_req_i |=> $stable(ch0_o) && $stable(ch1_o)); // R4
endmodule

bind audio_sample_formatter asf_checker #(.SAMP_W(SAMP_W), .ADDR_W(ADDR_W)) u_asf_checker (
  .clk           (clk),
  .rst           (rst),
  .en_i          (en_i),
  .wr_en_i       (wr_en_i),
  .wr_addr_i     (wr_addr_i),
  .samp_req_i    (samp_req_i),
  .tx_ready_o    (tx_ready_o),
  .tx_underrun_o (tx_underrun_o),
  .ch0_o         (ch0_o),
  .ch1_o         (ch1_o)
);

// File: tb/audio_sample_formatter_bench.sv
`timescale 1ns/1ps
module audio_sample_formatter_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0, mono = 1'b0, swap = 1'b0, wr_en = 1'b0, samp_req = 1'b0;
  logic [2:0]  fmt = 3'd4;
  logic [1:0]  wr_addr = 2'd0;
  logic [31:0] wr_data = '0;
  logic        tx_ready, tx_underrun;
  logic [15:0] ch0, ch1;

  int nvec = 0;
  int nfail = 0;
  logic [32:0] exp_q[$];
  logic        req_d = 1'b0;
  logic [15:0] last0 = '0, last1 = '0;

  always #10 clk = ~clk;

  audio_sample_formatter u_audio_sample_formatter (
    .clk (clk), .rst (rst), .en_i (en), .fmt_i (fmt), .mono_i (mono),
    .swap_i (swap), .wr_en_i (wr_en), .wr_addr_i (wr_addr),
    .wr_data_i (wr_data), .samp_req_i (samp_req), .tx_ready_o (tx_ready),
    .tx_underrun_o (tx_underrun), .ch0_o (ch0), .ch1_o (ch1)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] expv);
    nvec++;
    if (act !== expv) begin
      nfail++;
      $display("FAIL %s actual %h expected %h", r, act, expv);
    end
  endtask

  function automatic logic [15:0] scl(input logic [2:0] f, input logic [31:0] d);
    case (f)
      3'd0: return d[31:16];
      3'd1: return d[23:8];
      3'd2: return d[19:4];
      3'd3: return d[17:2];
      3'd6: return {d[7:0], 8'h00};
      default: return d[15:0];
    endcase
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic req_push(input logic [15:0] e0, input logic [15:0] e1, input logic eur);
    @(negedge clk);
    samp_req = 1'b1;
    exp_q.push_back({e0, e1, eur});
    @(negedge clk);
    samp_req = 1'b0;
  endtask

  task automatic frame(input string r, input logic [2:0] f, input logic m, input logic s,
                       input logic [31:0] a, input logic [31:0] b);
    logic [15:0] lo, hi, e0, e1;
    logic cmp;
    @(negedge clk);
    fmt = f; mono = m; swap = s;
    cmp = (f == 3'd5) || (f == 3'd7);
    lo  = (f == 3'd5) ? a[15:0]  : {a[7:0], 8'h00};
    hi  = (f == 3'd5) ? a[31:16] : {a[15:8], 8'h00};
    if (cmp) begin
      e0 = s ? hi : lo; e1 = s ? lo : hi;
    end else if (m) begin
      e0 = scl(f, a); e1 = e0;
    end else begin
      e0 = s ? scl(f, b) : scl(f, a);
      e1 = s ? scl(f, a) : scl(f, b);
    end
    wr(2'd0, a);
    if (!cmp && !m) chk({r, " R3 ready after A only"}, 32'(tx_ready), 32'd1);
    wr(2'd1, b);
    chk({r, " R2 ready low when complete"}, 32'(tx_ready), 32'd0);
    req_push(e0, e1, 1'b0);
    chk({r, " R2 ready back after request"}, 32'(tx_ready), 32'd1);
    last0 = e0; last1 = e1;
  endtask

  always @(posedge clk) req_d <= samp_req && !rst;

  always @(negedge clk) begin
    if (req_d) begin
      if (exp_q.size() == 0) begin
        nvec++; nfail++;
        $display("FAIL R4 unexpected request result actual %h expected none", {ch0, ch1});
      end else begin
        logic [32:0] e;
        e = exp_q.pop_front();
        chk("R4 ch0", 32'(ch0), 32'(e[32:17]));
        chk("R4 ch1", 32'(ch1), 32'(e[16:1]));
        chk("R4 underrun", 32'(tx_underrun), 32'(e[0]));
      end
    end
  end

  initial begin
    #(200000 * 20);
    nfail++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ready", 32'(tx_ready), 32'd0);
    chk("R1 underrun", 32'(tx_underrun), 32'd0);
    chk("R1 outputs", {ch0, ch1}, 32'd0);
    en = 1'b1;
    @(negedge clk);
    chk("R2 ready after enable", 32'(tx_ready), 32'd1);

    frame("R6 w16", 3'd4, 1'b0, 1'b0, 32'hDEAD_1234, 32'h0000_8001);
    frame("R6 w32", 3'd0, 1'b0, 1'b0, 32'h89AB_CDEF, 32'h0123_4567);
    frame("R6 w24", 3'd1, 1'b0, 1'b0, 32'hFF12_3456, 32'h00AB_CDEF);
    frame("R6 w20", 3'd2, 1'b0, 1'b0, 32'h000F_EDCB, 32'hFFF1_2345);
    frame("R6 w18", 3'd3, 1'b0, 1'b0, 32'h0003_FFFC, 32'h0001_0004);
    frame("R7 w8",  3'd6, 1'b0, 1'b0, 32'hFFFF_FF80, 32'h0000_007F);
    frame("R8 c16", 3'd5, 1'b0, 1'b0, 32'hAAAA_5555, 32'h0BAD_0BAD);
    frame("R9 c8",  3'd7, 1'b0, 1'b0, 32'hFFFF_C33C, 32'h0000_1111);
    frame("R10 swap", 3'd4, 1'b0, 1'b1, 32'h0000_1111, 32'h0000_2222);
    frame("R11 swap c16", 3'd5, 1'b0, 1'b1, 32'h1234_5678, 32'h0);
    frame("R11 swap c8", 3'd7, 1'b0, 1'b1, 32'h0000_A55A, 32'h0);
    frame("R12 mono", 3'd4, 1'b1, 1'b0, 32'h0000_7FFF, 32'h0000_0001);

    // R12: register B alone in mono does not complete a frame
    wr(2'd1, 32'h0000_4444);
    chk("R12 mono B ignored", 32'(tx_ready), 32'd1);
    frame("R12 mono swap", 3'd4, 1'b1, 1'b1, 32'h0000_3333, 32'h0000_4444);

    // R4 underrun with no frame, outputs repeat
    swap = 1'b0; mono = 1'b0;
    req_push(last0, last1, 1'b1);
    @(negedge clk);
    chk("R4 underrun sticky", 32'(tx_underrun), 32'd1);
    wr(2'd2, 32'h0);
    chk("R5 clear write", 32'(tx_underrun), 32'd0);
    req_push(last0, last1, 1'b1);

    // R5 / R13 disable
    en = 1'b0;
    @(negedge clk);
    chk("R5 underrun cleared by disable", 32'(tx_underrun), 32'd0);
    chk("R13 ready low disabled", 32'(tx_ready), 32'd0);
    wr(2'd0, 32'h0000_5A5A);
    wr(2'd1, 32'h0000_A5A5);
    req_push(last0, last1, 1'b0);
    chk("R13 ready still low", 32'(tx_ready), 32'd0);
    en = 1'b1;
    @(negedge clk);
    chk("R13 ready after re-enable", 32'(tx_ready), 32'd1);
    req_push(last0, last1, 1'b1);
    wr(2'd2, 32'h0);
    frame("R6 final", 3'd4, 1'b0, 1'b0, 32'h0000_0F0F, 32'h0000_F0F0);

    repeat (2) @(negedge clk);
    chk("R4 queue drained", 32'(exp_q.size()), 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule